// File: doc/BRIEF.md
# Serial NOR Flash Sector Rewriter

This block is the host side of a serial (SPI) link to an external NOR flash. The flash can only be erased a whole sector at a time, so changing any byte means rewriting the whole sector. One request names a sector, and the block then runs the full rewrite on its own. It reads every byte of the sector into a local sector buffer. It sends a write-enable and then the sector erase. It polls the flash status until the erase has finished. It then writes the buffer back one page at a time. Every page program is preceded by its own write-enable and followed by its own status poll.

The sector buffer sits outside the block and is reached through a simple address/data port. Read data must be presented in the same cycle as the address. The buffer contents may be altered between the read pass and the program pass, but that is the job of the surrounding logic. A status poll that keeps reporting busy for too long ends the run with a timeout pulse. The sector geometry, the serial clock divider and the width of the poll limit are all parameters.

Top module: `flash_sector_rewriter`

## Requirements
- R1: During and after reset the block is idle. Chip-select is high, the serial clock is low, and `busy`, `done` and `timeout` are low. Chip-select stays high whenever `busy` is low.
- R2: The first frame of a run is opcode 0x03 followed by three address bytes holding the sector number placed above the page and byte fields, with all lower bits zero. The whole sector is then clocked in, and each byte is written to the buffer with `buf_wr_en` at offsets 0, 1, 2 and so on, in ascending order. `buf_wr_data` carries the byte.
- R3: A one-byte frame carrying opcode 0x06 is sent immediately before the erase frame and immediately before every page-program frame.
- R4: The erase frame is opcode 0xD8 plus three address bytes and nothing more. Chip-select rises on the same clock on which the serial clock falls after the eighth bit of the last address byte. No frame ends in the middle of a byte.
- R5: After the erase and after each page program, the block sends two-byte frames: opcode 0x05, then one status byte read back. It repeats these frames while bit 0 of the status byte is 1 and moves on once that bit reads 0.
- R6: Pages are programmed in ascending order. Each program frame is opcode 0x02, the address {sector, page, zero byte field}, and then one full page of data. The data is taken from buffer offsets page*PAGE_BYTES onward. The run therefore issues exactly one program frame per page.
- R7: The serial link runs in SPI mode 0 with the most significant bit first. The clock is low when idle and each high phase lasts exactly SCK_HALF system clocks. The output data line changes only while the serial clock is low.
- R8: Between two frames, chip-select stays high for at least 2*SCK_HALF system clocks.
- R9: If `poll_limit` status reads in a row report busy, the block pulses `timeout` for one cycle and returns to idle. It issues no further frames. A limit of 0 acts as 1.
- R10: When the final poll of the last page reads not-busy, `done` pulses for one cycle and `busy` falls. Any request made while `busy` is high is ignored.
- R11: A run changes only the requested sector. Every byte of every other sector is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a sector rewrite; accepted only while idle |
| req_sector | input | SECT_W | Sector to rewrite |
| poll_limit | input | POLL_W | Maximum consecutive busy status reads |
| busy | output | 1 | A rewrite is in progress |
| done | output | 1 | One-cycle pulse when a rewrite completes |
| timeout | output | 1 | One-cycle pulse when polling gives up |
| buf_addr | output | PAGE_W+BYTE_W | Byte offset in the sector buffer |
| buf_wr_en | output | 1 | Write `buf_wr_data` to the buffer at `buf_addr` |
| buf_wr_data | output | 8 | Byte read from flash |
| buf_rd_data | input | 8 | Buffer byte at `buf_addr`, same cycle |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip-select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions assume three things about the inputs. The buffer answers `buf_rd_data` in the same cycle as the address. `poll_limit` is only changed while the block is idle. `rst_n` is released cleanly, before any request is made. The bench keeps within these assumptions: its buffer model is a plain array read combinationally, the limit is rewritten only between runs, and requests are driven on the falling clock edge. The flash model on the far side only accepts an erase or program that follows a write-enable and a frame cut on a byte boundary. Any slip in sequencing or framing therefore shows up as wrong sector contents or as counted rejected frames.

// File: rtl/flash_sector_rewriter.sv
module flash_sector_rewriter #(
  parameter int SCK_HALF = 2,
  parameter int SECT_W   = 3,
  parameter int PAGE_W   = 8,
  parameter int BYTE_W   = 8,
  parameter int POLL_W   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [SECT_W-1:0]         req_sector,
  input  logic [POLL_W-1:0]         poll_limit,
  output logic                      busy,
  output logic                      done,
  output logic                      timeout,
  output logic [PAGE_W+BYTE_W-1:0]  buf_addr,
  output logic                      buf_wr_en,
  output logic [7:0]                buf_wr_data,
  input  logic [7:0]                buf_rd_data,
  output logic                      spi_sck,
  output logic                      spi_cs_n,
  output logic                      spi_mosi,
  input  logic                      spi_miso
);

  localparam int OFS_W      = PAGE_W + BYTE_W;
  localparam int ADDR_W     = SECT_W + OFS_W;
  localparam int SECT_BYTES = 1 << OFS_W;
  localparam int PAGE_BYTES = 1 << BYTE_W;
  localparam int CNT_W      = OFS_W + 2;
  localparam int DIV_W      = $clog2(SCK_HALF + 1);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_XFER} st_t;
  typedef enum logic [2:0] {P_READ, P_WEN_E, P_ERASE, P_POLL_E, P_WEN_P, P_PROG, P_POLL_P} ph_t;

  st_t               st;
  ph_t               ph;
  logic [SECT_W-1:0] sector;
  logic [PAGE_W-1:0] page;
  logic [DIV_W-1:0]  div;
  logic              gap_half;
  logic              sck, cs_n;
  logic [7:0]        tx, rx;
  logic [2:0]        bitc;
  logic [CNT_W-1:0]  bcnt;
  logic [POLL_W-1:0] pcnt;
  logic              done_r, tmo_r;

  logic              tick, byte_end, last_byte;
  logic [CNT_W-1:0]  nbytes;
  logic [ADDR_W-1:0] flash_addr;
  logic [23:0]       addr24;
  logic [7:0]        next_byte, opcode;

  assign tick     = (st != S_IDLE) && (div == DIV_W'(SCK_HALF - 1));
  assign byte_end = (st == S_XFER) && tick && sck && (bitc == 3'd7);

  always_comb begin
    case (ph)
      P_READ:             begin nbytes = CNT_W'(4 + SECT_BYTES); opcode = 8'h03; end
      P_WEN_E, P_WEN_P:   begin nbytes = CNT_W'(1);              opcode = 8'h06; end
      P_ERASE:            begin nbytes = CNT_W'(4);              opcode = 8'hD8; end
      P_PROG:             begin nbytes = CNT_W'(4 + PAGE_BYTES); opcode = 8'h02; end
      default:            begin nbytes = CNT_W'(2);              opcode = 8'h05; end
    endcase
  end

  assign last_byte  = (bcnt == nbytes - CNT_W'(1));
  assign flash_addr = {sector, (ph == P_PROG) ? page : {PAGE_W{1'b0}}, {BYTE_W{1'b0}}};
  assign addr24     = 24'(flash_addr);

  always_comb begin
    case (bcnt + CNT_W'(1))
      CNT_W'(1): next_byte = addr24[23:16];
      CNT_W'(2): next_byte = addr24[15:8];
      CNT_W'(3): next_byte = addr24[7:0];
      default:   next_byte = (ph == P_PROG) ? buf_rd_data : 8'h00;
    endcase
  end

  assign buf_addr    = (ph == P_PROG) ? {page, BYTE_W'(bcnt - CNT_W'(3))}
                                      : OFS_W'(bcnt - CNT_W'(4));
  assign buf_wr_en   = byte_end && (ph == P_READ) && (bcnt >= CNT_W'(4));
  assign buf_wr_data = rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= P_READ;
      sector   <= '0;
      page     <= '0;
      div      <= '0;
      gap_half <= 1'b0;
      sck      <= 1'b0;
      cs_n     <= 1'b1;
      tx       <= '0;
      rx       <= '0;
      bitc     <= '0;
      bcnt     <= '0;
      pcnt     <= '0;
      done_r   <= 1'b0;
      tmo_r    <= 1'b0;
    end else begin
      done_r <= 1'b0;
      tmo_r  <= 1'b0;
      if (st == S_IDLE || tick) div <= '0;
      else                      div <= div + DIV_W'(1);

      case (st)
        S_IDLE: if (req_valid) begin
          sector   <= req_sector;
          page     <= '0;
          ph       <= P_READ;
          st       <= S_GAP;
          gap_half <= 1'b0;
        end
        S_GAP: if (tick) begin
          if (gap_half) begin
            st   <= S_XFER;
            cs_n <= 1'b0;
            tx   <= opcode;
            bcnt <= '0;
            bitc <= '0;
          end else begin
            gap_half <= 1'b1;
          end
        end
        S_XFER: if (tick) begin
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], spi_miso};
          end else begin
            sck <= 1'b0;
            if (bitc != 3'd7) begin
              bitc <= bitc + 3'd1;
              tx   <= {tx[6:0], 1'b0};
            end else begin
              bitc <= '0;
              if (!last_byte) begin
                bcnt <= bcnt + CNT_W'(1);
                tx   <= next_byte;
              end else begin
                cs_n     <= 1'b1;
                st       <= S_GAP;
                gap_half <= 1'b0;
                case (ph)
                  P_READ:  ph <= P_WEN_E;
                  P_WEN_E: ph <= P_ERASE;
                  P_ERASE: begin ph <= P_POLL_E; pcnt <= '0; end
                  P_WEN_P: ph <= P_PROG;
                  P_PROG:  begin ph <= P_POLL_P; pcnt <= '0; end
                  P_POLL_E, P_POLL_P: begin
                    if (rx[0]) begin
                      if (({1'b0, pcnt} + (POLL_W+1)'(1)) >= {1'b0, poll_limit}) begin
                        st    <= S_IDLE;
                        tmo_r <= 1'b1;
                      end else begin
                        pcnt <= pcnt + POLL_W'(1);
                      end
                    end else if (ph == P_POLL_E) begin
                      ph <= P_WEN_P;
                    end else if (page != {PAGE_W{1'b1}}) begin
                      ph   <= P_WEN_P;
                      page <= page + PAGE_W'(1);
                    end else begin
                      st     <= S_IDLE;
                      done_r <= 1'b1;
                    end
                  end
                  default: ph <= P_READ;
                endcase
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = done_r;
  assign timeout  = tmo_r;
  assign spi_sck  = sck;
  assign spi_cs_n = cs_n;
  assign spi_mosi = tx[7];

endmodule

// File: rtl/flash_sector_rewriter_chk.sv
module flash_sector_rewriter_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic timeout,
  input logic buf_wr_en,
  input logic spi_sck,
  input logic spi_cs_n,
  input logic spi_mosi
);

  // R1
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);

  // R7
  sck_low_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R7
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R4
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> $fell(spi_sck));

  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  // R2
  buf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> (!spi_cs_n && spi_sck));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !timeout && spi_cs_n));

  // R9
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!busy && spi_cs_n));

endmodule

bind flash_sector_rewriter flash_sector_rewriter_chk i_chk (.*);

// File: tb/test_flash_sector_rewriter.sv
module test_flash_sector_rewriter;
  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 2;
  localparam int SECT_W     = 3;
  localparam int PAGE_W     = 2;
  localparam int BYTE_W     = 2;
  localparam int POLL_W     = 8;
  localparam int SB         = 1 << (PAGE_W + BYTE_W);
  localparam int NPAGE      = 1 << PAGE_W;
  localparam int PB         = 1 << BYTE_W;
  localparam int TOTAL      = SB << SECT_W;
  localparam int P_POLLS    = 1;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [SECT_W-1:0] req_sector = '0;
  logic [POLL_W-1:0] poll_limit = 8'd8;
  logic busy, done, timeout, buf_wr_en, spi_sck, spi_cs_n, spi_mosi, spi_miso;
  logic [PAGE_W+BYTE_W-1:0] buf_addr;
  logic [7:0] buf_wr_data, buf_rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_sector_rewriter #(.SCK_HALF(SCK_HALF), .SECT_W(SECT_W), .PAGE_W(PAGE_W),
    .BYTE_W(BYTE_W), .POLL_W(POLL_W)) i_flash_sector_rewriter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sector(req_sector),
    .poll_limit(poll_limit), .busy(busy), .done(done), .timeout(timeout),
    .buf_addr(buf_addr), .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data),
    .buf_rd_data(buf_rd_data), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int n_checks = 0, n_err = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] orig(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  // sector buffer model
  logic [7:0] bmem [SB];
  logic [7:0] key;
  logic [7:0] exp_mem [TOTAL];
  int cur_sector = 0, wr_idx = 0, wr_bad = 0;
  assign buf_rd_data = bmem[buf_addr];
  always @(negedge clk) if (rst_n && buf_wr_en) begin
    if (int'(buf_addr) != wr_idx) wr_bad++;
    if (buf_wr_data != exp_mem[cur_sector * SB + int'(buf_addr)]) wr_bad++;
    bmem[buf_addr] = buf_wr_data ^ key;
    wr_idx++;
  end

  // flash model
  logic [7:0] fmem [TOTAL];
  logic [7:0] f_sh = 0, f_op = 0, f_out = 0, f_nxt = 0;
  int f_bits = 0, f_bytes = 0, f_addr = 0, f_wip = 0, e_polls = 0, fk, fa;
  bit f_wel = 0, f_stuck = 0;
  int n_status = 0, n_wren = 0, n_erase = 0, n_prog = 0, n_read = 0;
  int n_reject = 0, n_badframe = 0, n_frames = 0;
  assign spi_miso = f_out[7];

  always @(negedge spi_cs_n) begin
    f_bits = 0; f_bytes = 0; f_nxt = 0; f_out = 0; n_frames++;
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    f_sh = {f_sh[6:0], spi_mosi};
    f_bits++;
    if (f_bits == 8) begin
      f_bits = 0;
      if (f_bytes == 0) begin f_op = f_sh; f_addr = 0; end
      else if (f_bytes <= 3) f_addr = (f_addr << 8) | int'(f_sh);
      else if (f_op == 8'h02 && f_wel) begin
        fk = f_bytes - 4;
        fa = ((f_addr % TOTAL) & ~(PB - 1)) | ((f_addr + fk) & (PB - 1));
        fmem[fa] = fmem[fa] & f_sh;
      end
      f_bytes++;
      if (f_op == 8'h05) f_nxt = {7'b0, (f_wip > 0) || f_stuck};
      else if (f_op == 8'h03 && f_bytes >= 4) f_nxt = fmem[(f_addr + f_bytes - 4) % TOTAL];
      else f_nxt = 0;
    end
  end

  always @(negedge spi_sck) if (!spi_cs_n) begin
    if (f_bits == 0) f_out = f_nxt;
    else f_out = {f_out[6:0], 1'b0};
  end

  always @(posedge spi_cs_n) begin
    if (f_bits != 0) n_badframe++;
    else case (f_op)
      8'h06: if (f_bytes == 1) begin f_wel = 1; n_wren++; end else n_badframe++;
      8'hD8: if (f_bytes == 4) begin
               if (f_wel) begin
                 for (int i = 0; i < SB; i++) fmem[((f_addr % TOTAL) / SB) * SB + i] = 8'hFF;
                 f_wip = e_polls; n_erase++;
               end else n_reject++;
               f_wel = 0;
             end else n_badframe++;
      8'h02: if (f_bytes == 4 + PB) begin
               if (f_wel) begin f_wip = P_POLLS; n_prog++; end else n_reject++;
               f_wel = 0;
             end else n_badframe++;
      8'h05: if (f_bytes == 2) begin n_status++; if (f_wip > 0) f_wip--; end else n_badframe++;
      8'h03: if (f_bytes == 4 + SB) n_read++; else n_badframe++;
      default: ;
    endcase
  end

  // serial-link timing monitor
  bit prev_sck = 0, prev_mosi = 0, prev_cs = 1;
  int hi_run = 0, hi_cs = 0, mode_bad = 0, gap_bad = 0, seen = 0;
  always @(negedge clk) if (rst_n) begin
    if (spi_sck) begin
      if (prev_sck && spi_mosi != prev_mosi) mode_bad++;
      hi_run++;
    end else begin
      if (prev_sck && hi_run != SCK_HALF) mode_bad++;
      hi_run = 0;
    end
    if (spi_cs_n) hi_cs++;
    else begin
      if (prev_cs && seen > 0 && hi_cs < 2 * SCK_HALF) gap_bad++;
      if (prev_cs) seen++;
      hi_cs = 0;
    end
    prev_sck = spi_sck; prev_mosi = spi_mosi; prev_cs = spi_cs_n;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL R10: watchdog expired, actual 0 expected 1 completion");
    finish_run();
  end

  task automatic run(input int s, output bit got_done, output bit got_tmo);
    @(negedge clk);
    req_valid = 1; req_sector = SECT_W'(s);
    @(negedge clk);
    req_valid = 0;
    repeat (60) @(negedge clk);
    req_valid = 1; req_sector = SECT_W'((s + 4) % 8);
    @(negedge clk);
    req_valid = 0;
    while (!done && !timeout) @(negedge clk);
    got_done = done; got_tmo = timeout;
  endtask

  initial begin
    bit gd, gt;
    int s_st, s_wr, s_er, s_pr, s_rd, s_rj, s_fr, bad_t, bad_o;
    for (int i = 0; i < TOTAL; i++) begin fmem[i] = orig(i); exp_mem[i] = orig(i); end
    for (int i = 0; i < SB; i++) bmem[i] = 0;
    key = 0;
    repeat (3) @(negedge clk);
    check(spi_cs_n && !spi_sck && !busy && !done && !timeout, "R1 in reset", 0, 1);
    rst_n = 1;
    @(negedge clk);
    check(spi_cs_n && !spi_sck && !busy && !done && !timeout, "R1 after reset", 0, 1);

    for (int s = 0; s < 8; s++) begin
      key = 8'(s * 29 + 1); e_polls = s % 4; cur_sector = s; wr_idx = 0;
      s_st = n_status; s_wr = n_wren; s_er = n_erase; s_pr = n_prog;
      s_rd = n_read; s_rj = n_reject;
      run(s, gd, gt);
      check(gd && !gt, "R10 done pulse", int'(gd), 1);
      @(negedge clk);
      check(!done && !busy, "R10 done one cycle", int'(done), 0);
      check(wr_idx == SB && wr_bad == 0, "R2 buffer fill", wr_idx, SB);
      check(n_read - s_rd == 1, "R10 one read frame, request while busy ignored", n_read - s_rd, 1);
      check(n_wren - s_wr == 1 + NPAGE && n_reject == s_rj, "R3 write-enable count",
            n_wren - s_wr, 1 + NPAGE);
      check(n_erase - s_er == 1, "R4 erase count", n_erase - s_er, 1);
      check(n_status - s_st == e_polls + 1 + NPAGE * (P_POLLS + 1), "R5 status reads",
            n_status - s_st, e_polls + 1 + NPAGE * (P_POLLS + 1));
      check(n_prog - s_pr == NPAGE, "R6 program frames", n_prog - s_pr, NPAGE);
      for (int i = 0; i < SB; i++) exp_mem[s * SB + i] = exp_mem[s * SB + i] ^ key;
      bad_t = 0; bad_o = 0;
      for (int i = 0; i < TOTAL; i++)
        if (fmem[i] != exp_mem[i]) begin
          if (i / SB == s) bad_t++; else bad_o++;
        end
      check(bad_t == 0, "R6 sector rewritten", bad_t, 0);
      check(bad_o == 0, "R11 other sectors unchanged", bad_o, 0);
    end
    check(mode_bad == 0, "R7 mode 0 timing", mode_bad, 0);
    check(gap_bad == 0, "R8 deselect gap", gap_bad, 0);
    check(n_badframe == 0, "R4 byte-aligned frame ends", n_badframe, 0);

    f_stuck = 1;
    for (int lim = 5; lim >= 0; lim -= 5) begin
      poll_limit = POLL_W'(lim);
      s_st = n_status;
      cur_sector = 2; wr_idx = 0; key = 8'h11;
      run(2, gd, gt);
      check(gt && !gd, "R9 timeout pulse", int'(gt), 1);
      check(n_status - s_st == (lim == 0 ? 1 : lim), "R9 busy reads before timeout",
            n_status - s_st, lim == 0 ? 1 : lim);
      s_fr = n_frames;
      repeat (100) @(negedge clk);
      check(n_frames == s_fr && spi_cs_n && !busy, "R9 no frames after timeout",
            n_frames - s_fr, 0);
      for (int i = 0; i < SB; i++) exp_mem[2 * SB + i] = fmem[2 * SB + i];
    end
    finish_run();
  end
endmodule